// File: doc/BRIEF.md
# Sign-Randomized 16-Point Hadamard Mixer

This block mixes a vector of 16 signed fixed-point samples with an orthonormal 16-point Walsh-Hadamard matrix. In forward mode each lane is first multiplied by a fixed ±1 taken from a constant sign mask. Four add/subtract butterfly stages follow, and the result is scaled by 1/4 so that vector energy is kept. Outliers concentrated in a few lanes are spread evenly across all lanes, which makes the vector easier to quantize with one scale for the whole group.

The matrix is orthogonal, so the inverse is its transpose. In inverse mode the butterflies run first and the same sign mask is applied at the end. A vector sent through the forward mode and then through the inverse mode comes back to the original values, apart from rounding.

Vectors enter in parallel through a valid/ready handshake, one per clock. They leave in parallel after a fixed pipeline delay. Backpressure at the output stalls the whole pipeline.

Top module: `rht16_mixer`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Forward mode (`in_inverse`=0). Input lane j is `in_data[j*W +: W]`, read as two's complement. Set s_j = -1 when bit j of `SIGN_MASK` is 1 (default 16'h6B2D), otherwise s_j = +1. Output lane i is `out_data[i*(W+3) +: W+3]` and equals round(Σ_j (-1)^popcount(i&j) · s_j · x_j / 4).
- R3: Inverse mode (`in_inverse`=1). Output lane i equals s_i · round(Σ_j (-1)^popcount(i&j) · x_j / 4), with the same lane layout and mask as R2.
- R4: With `out_ready` held at 1, a vector accepted on a clock edge appears with `out_valid`=1 after exactly 5 rising edges, counting the accepting edge. The block accepts one vector per cycle.
- R5: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_valid` and `out_data` hold their values on the next cycle.
- R6: Every accepted vector is delivered exactly once and in the order of acceptance. At most 5 vectors are in flight at any time.
- R7: round() divides by 4 and rounds half to even. A quotient of ±0.5 gives 0, and a quotient of ±1.5 gives ±2.
- R8: Full-scale inputs do not overflow. This includes every lane at -2^(W-1) in either mode, and outputs reach ±2^(W+1).
- R9: A vector sent forward, whose result is then sent through the inverse mode, returns each lane within ±2 of its original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can accept a vector |
| in_inverse | input | 1 | 1 selects the inverse transform for this vector |
| in_data | input | 16*W | 16 signed lanes, lane j at bits j*W upward |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts the output vector |
| out_data | output | 16*(W+3) | 16 signed result lanes |

## Verification
A vector accepted on a rising edge is due at the output after the fifth rising edge, counting the accepting edge. That delay grows by one cycle for every cycle in which `out_ready` holds the output back. Inputs are driven on the falling edge, and the handshakes are sampled 1 ns later, before the next rising edge. Each accepted vector pushes its arithmetically computed result into an ordered queue. Each output handshake pops the queue and compares, so stalls do not change the result. A dedicated run checks `out_valid` after each of the five edges that follow a single acceptance. Another holds `out_ready` low and checks that the output stays stable across cycles.

// File: rtl/rht16_mixer.sv
`timescale 1ns/1ps
module rht16_mixer #(
  parameter int          W         = 12,
  parameter logic [15:0] SIGN_MASK = 16'h6B2D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_inverse,
  input  logic [16*W-1:0]     in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [16*(W+3)-1:0] out_data
);
  localparam int N      = 16;
  localparam int STAGES = $clog2(N);
  localparam int AW     = W + STAGES + 1;
  localparam int OW     = W + 3;

  logic signed [AW-1:0] pipe [STAGES+1][N];
  logic [STAGES:0] vld;
  logic [STAGES:0] inv;
  logic advance;

  assign advance   = ~vld[STAGES] | out_ready;
  assign in_ready  = advance;
  assign out_valid = vld[STAGES];

  function automatic logic signed [AW-1:0] widen(input logic [W-1:0] v);
    return AW'(signed'(v));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (advance) vld <= {vld[STAGES-1:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      inv <= {inv[STAGES-1:0], in_inverse};
      for (int i = 0; i < N; i++) begin
        if (!in_inverse && SIGN_MASK[i]) pipe[0][i] <= -widen(in_data[i*W +: W]);
        else                             pipe[0][i] <=  widen(in_data[i*W +: W]);
      end
      for (int k = 0; k < STAGES; k++) begin
        for (int i = 0; i < N; i++) begin
          if (((i >> k) & 1) == 0) pipe[k+1][i] <= pipe[k][i] + pipe[k][i + (1 << k)];
          else                     pipe[k+1][i] <= pipe[k][i - (1 << k)] - pipe[k][i];
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] shifted;
    logic signed [OW-1:0] rounded;
    logic                 bump;
    assign sum     = pipe[STAGES][i];
    assign bump    = sum[1] & (sum[0] | sum[2]);
    assign shifted = (sum >>> 2) + AW'(bump);
    assign rounded = shifted[OW-1:0];
    assign out_data[i*OW +: OW] = (inv[STAGES] && SIGN_MASK[i]) ? -rounded : rounded;
  end
endmodule

module rht16_mixer_chk #(
  parameter int OW = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [16*OW-1:0] out_data
);
  logic [3:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (!out_valid);
  end

  a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r5_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r4_ready_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r6_bounded_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'd5);

  a_r6_no_phantom_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 4'd0);
endmodule

bind rht16_mixer rht16_mixer_chk #(.OW(W + 3)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/rht16_mixer_tb_top.sv
`timescale 1ns/1ps
module rht16_mixer_tb_top;
  localparam int          W    = 12;
  localparam int          OW   = W + 3;
  localparam int          N    = 16;
  localparam logic [15:0] MASK = 16'h6B2D;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready, in_inverse = 0, out_valid, out_ready = 0;
  logic [N*W-1:0]  in_data = '0;
  logic [N*OW-1:0] out_data;

  int checks = 0, errors = 0;
  logic [N*OW-1:0] expq[$];
  string tagq[$];
  logic [N*OW-1:0] last_out;
  bit out_seen;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  rht16_mixer #(.W(W), .SIGN_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inverse(in_inverse), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [N*OW-1:0] model(input logic [N*W-1:0] x, input bit inv);
    int xs[N];
    logic [N*OW-1:0] r;
    for (int j = 0; j < N; j++) begin
      xs[j] = signed'(x[j*W +: W]);
      if (!inv && MASK[j]) xs[j] = -xs[j];
    end
    for (int i = 0; i < N; i++) begin
      int acc, q, rem;
      acc = 0;
      for (int j = 0; j < N; j++)
        acc += ($countones(i & j) % 2 == 1) ? -xs[j] : xs[j];
      q = acc >>> 2;
      rem = acc - 4 * q;
      if (rem == 3 || (rem == 2 && (q & 1) == 1)) q = q + 1;
      if (inv && MASK[i]) q = -q;
      r[i*OW +: OW] = q[OW-1:0];
    end
    return r;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N*W-1:0] x, input bit inv, input bit v, input bit rdy, input string tag);
    @(negedge clk);
    in_data = x; in_inverse = inv; in_valid = v; out_ready = rdy;
    #1;
    out_seen = 0;
    if (in_valid && in_ready) begin
      expq.push_back(model(x, inv));
      tagq.push_back(tag);
    end
    if (out_valid && out_ready) begin
      out_seen = 1;
      last_out = out_data;
      if (expq.size() == 0) check("R6 unexpected output", 0, 1, 0);
      else begin
        logic [N*OW-1:0] e;
        string t;
        int bad;
        e = expq.pop_front();
        t = tagq.pop_front();
        bad = -1;
        for (int i = N - 1; i >= 0; i--) if (out_data[i*OW +: OW] !== e[i*OW +: OW]) bad = i;
        if (bad < 0) check(t, 1, 0, 0);
        else check($sformatf("%s lane %0d", t, bad), 0,
                   int'(signed'(out_data[bad*OW +: OW])), int'(signed'(e[bad*OW +: OW])));
      end
    end
  endtask

  task automatic drain();
    repeat (8) step('0, 0, 0, 1, "R6");
  endtask

  function automatic logic [N*W-1:0] fill(input int a);
    logic [N*W-1:0] r;
    for (int j = 0; j < N; j++) r[j*W +: W] = a[W-1:0];
    return r;
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 out_valid in reset", out_valid == 0, out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 out_valid after reset", out_valid == 0, out_valid, 0);
    check("R1 in_ready after reset", in_ready == 1, in_ready, 1);

    // R4: a single vector is due after the fifth rising edge
    step(fill(3), 0, 1, 1, "R4");
    for (int k = 1; k <= 5; k++) begin
      step('0, 0, 0, 1, "R4");
      check($sformatf("R4 out_valid after edge %0d", k), out_valid == (k == 5), out_valid, k == 5);
    end
    drain();

    // R2/R3/R7/R8: impulses on every lane, both modes, streamed back to back
    for (int m = 0; m < 2; m++)
      for (int j = 0; j < N; j++)
        for (int a = 0; a < 7; a++) begin
          int amp[7] = '{1, -1, 2, 6, -6, 2047, -2048};
          logic [N*W-1:0] x;
          string t;
          x = '0;
          x[j*W +: W] = amp[a][W-1:0];
          t = (a >= 2 && a <= 4) ? "R7" : (a >= 5) ? "R8" : (m == 1) ? "R3" : "R2";
          step(x, m[0], 1, 1, t);
        end
    drain();

    // R8: full-scale constant vectors
    for (int m = 0; m < 2; m++) begin
      step(fill(-2048), m[0], 1, 1, "R8");
      step(fill(2047), m[0], 1, 1, "R8");
      step(fill(7), m[0], 1, 1, m == 0 ? "R2" : "R3");
    end
    drain();

    // R5: backpressure fills the pipeline and holds the output
    for (int k = 0; k < 8; k++) step({N*W/32+1{rnd()}}, k[0], 1, 0, "R5");
    begin
      logic [N*OW-1:0] held;
      check("R5 in_ready blocked", in_ready == 0, in_ready, 0);
      check("R5 out_valid held", out_valid == 1, out_valid, 1);
      held = out_data;
      for (int k = 0; k < 3; k++) begin
        step('0, 0, 1, 0, "R5");
        check("R5 out_data stable", out_data == held, 0, 0);
      end
    end
    drain();

    // R6: random traffic with random stalls, both modes
    for (int k = 0; k < 400; k++) begin
      logic [N*W-1:0] x;
      logic [31:0] c;
      for (int j = 0; j < N; j++) x[j*W +: W] = rnd()[W-1:0];
      c = rnd();
      step(x, c[0], c[1] | c[2], c[3] | c[4], "R6");
    end
    drain();
    check("R6 every vector delivered", expq.size() == 0, expq.size(), 0);

    // R9: forward then inverse round trip through the block
    for (int k = 0; k < 20; k++) begin
      logic [N*W-1:0] x, y;
      logic [N*OW-1:0] fwd, back;
      int worst;
      for (int j = 0; j < N; j++) x[j*W +: W] = W'(int'(rnd() % 201) - 100);
      step(x, 0, 1, 1, "R9");
      for (int t = 0; t < 6; t++) begin
        step('0, 0, 0, 1, "R9");
        if (out_seen) fwd = last_out;
      end
      for (int j = 0; j < N; j++) y[j*W +: W] = fwd[j*OW +: W];
      step(y, 1, 1, 1, "R9");
      for (int t = 0; t < 6; t++) begin
        step('0, 0, 0, 1, "R9");
        if (out_seen) back = last_out;
      end
      worst = 0;
      for (int j = 0; j < N; j++) begin
        int d;
        d = int'(signed'(back[j*OW +: OW])) - int'(signed'(x[j*W +: W]));
        if (d < 0) d = -d;
        if (d > worst) worst = d;
      end
      check("R9 round trip error", worst <= 2, worst, 2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule